// File: doc/BRIEF.md
# USB Transmit Endpoint Control

This block is the control and status logic for one transmit endpoint of a USB host or peripheral controller. Software programs it through a byte-wide register port: a control byte, a packet-ready status bit, a maximum packet size, and a read-only fill count. The FIFO that holds the data sits outside the block. The FIFO logic pulses a load strobe for every byte written into that FIFO. The block counts those bytes and can raise packet-ready by itself once a full maximum-size packet has been loaded.

The block keeps the endpoint data toggle. The toggle flips on each acknowledged transaction. Software can also flip it by force, which flushes the pending packet whether or not an ACK arrived. Software can instead load an explicit toggle value. The block drives a DMA request line in two request modes and selects the direction of a FIFO that is shared between transmit and receive. It reports a protocol error when software clears the DMA mode bit in the wrong order relative to the DMA enable bit.

Top module: `tx_ep_ctrl`

## Requirements
- R1: After reset, all control bits, the data toggle, packet-ready, the fill count and the maximum packet size are 0. The outputs dma_req_o, flush_o, err_o and dir_tx_o are low, and every register address reads 0x00.
- R2: Each load_i strobe increases the fill count by one, up to a limit of FIFO_DEPTH. The count reads back at address 3.
- R3: Packet-ready reads at address 0 bit 0. When control bit 2 (auto-ready) is 1, the load that makes the count equal to the maximum packet size (address 2) sets packet-ready on the same clock edge. When auto-ready is 0, that load leaves packet-ready clear. Writing 1 to address 0 bit 0 sets packet-ready.
- R4: When done_i and ack_i are high together, the data toggle inverts, packet-ready clears and the count returns to 0. When done_i is high without ack_i, none of these change.
- R5: Writing 1 to control bit 4 inverts the toggle, clears packet-ready and the count, and drives flush_o high for the next cycle only. If an ACK completion falls in the same cycle, the toggle inverts only once.
- R6: Writing 1 to control bit 5 loads control bit 6 of the same write into the toggle. This load takes priority over any inversion in that cycle. Control bit 6 reads back the current toggle, and bit 5 always reads 0.
- R7: dma_req_o is low while control bit 0 (DMA enable) is 0. When control bit 1 (DMA mode) is 0, dma_req_o is high when packet-ready is clear and count plus maximum packet size is at most FIFO_DEPTH. When DMA mode is 1, dma_req_o is high when packet-ready is clear and the count is below the maximum packet size.
- R8: A control write that clears bit 1 while bits 0 and 1 are both currently set drives err_o high for the next cycle. A write that clears bit 1 while bit 0 is clear does not raise err_o.
- R9: When SHARED_FIFO is 1, dir_tx_o follows control bit 3 (1 means transmit). When SHARED_FIFO is 0, dir_tx_o is constantly 1.
- R10: Control bit 7 and status bits 7:1 read 0 and are unaffected by writes. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data at addr_i (combinational) |
| load_i | input | 1 | One byte loaded into the transmit FIFO |
| done_i | input | 1 | Transaction complete |
| ack_i | input | 1 | Transaction was acknowledged (valid with done_i) |
| dma_req_o | output | 1 | DMA request |
| flush_o | output | 1 | Pulse: discard the pending FIFO packet |
| err_o | output | 1 | Pulse: DMA mode/enable ordering violation |
| dir_tx_o | output | 1 | Shared FIFO direction, 1 = transmit |

## Verification
The bench checks each of these states through the register port or the output pins at the first negative edge after the write or strobe that changed it. A wrong fill count is visible at address 3 immediately, and it also moves the auto-ready edge by one load and changes dma_req_o in mode 1. A toggle that inverts twice, or not at all, shows as a wrong bit 6 at address 1 after the completion cycle. A missing pulse on flush_o or err_o, or a pulse that lasts two cycles, shows in the cycle after the triggering write and in the cycle after that.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_CTRL = 2'd1,
    A_MPS  = 2'd2,
    A_CNT  = 2'd3
  } addr_e;

  // control byte bit positions
  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_AUTO  = 2;
  localparam int CB_DIR   = 3;
  localparam int CB_FORCE = 4;
  localparam int CB_TLD   = 5;
  localparam int CB_TVAL  = 6;

  typedef struct packed {
    logic dir_tx;
    logic auto_rdy;
    logic dma_mode;
    logic dma_en;
  } ctrl_t;
endpackage

// File: rtl/tx_ep_regs.sv
module tx_ep_regs
  import tx_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] mps_o,
  output logic              force_stb_o,
  output logic              tog_ld_stb_o,
  output logic              tog_val_o,
  output logic              rdy_set_stb_o,
  output logic              err_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mps_q;
  logic              err_q;
  logic              ctrl_wr;
  logic              unused_bits;

  assign ctrl_wr       = wr_en_i && (addr_e'(addr_i) == A_CTRL);
  assign force_stb_o   = ctrl_wr && wdata_i[CB_FORCE];
  assign tog_ld_stb_o  = ctrl_wr && wdata_i[CB_TLD];
  assign tog_val_o     = wdata_i[CB_TVAL];
  assign rdy_set_stb_o = wr_en_i && (addr_e'(addr_i) == A_STAT) && wdata_i[0];
  assign unused_bits   = wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mps_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      // mode cleared while DMA still enabled, or together with enable
      err_q <= ctrl_wr && ctrl_q.dma_en && ctrl_q.dma_mode && !wdata_i[CB_MODE];
      if (ctrl_wr) begin
        ctrl_q.dma_en   <= wdata_i[CB_EN];
        ctrl_q.dma_mode <= wdata_i[CB_MODE];
        ctrl_q.auto_rdy <= wdata_i[CB_AUTO];
        ctrl_q.dir_tx   <= wdata_i[CB_DIR];
      end
      if (wr_en_i && (addr_e'(addr_i) == A_MPS)) mps_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mps_o  = mps_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tx_ep_pkt.sv
module tx_ep_pkt
  import tx_ep_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic              force_stb_i,
  input  logic              tog_ld_stb_i,
  input  logic              tog_val_i,
  input  logic              rdy_set_stb_i,
  input  logic              auto_rdy_i,
  input  logic [DATA_W-1:0] mps_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pkt_rdy_o,
  output logic              tog_o,
  output logic              flush_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pkt_rdy_q, tog_q, flush_q;
  logic             clr, can_load, hit_mps;

  assign clr      = force_stb_i || (done_i && ack_i);
  assign can_load = load_i && (int'(cnt_q) < FIFO_DEPTH);
  assign hit_mps  = can_load && ((int'(cnt_q) + 1) == int'(mps_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pkt_rdy_q <= 1'b0;
      tog_q     <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      flush_q <= force_stb_i;
      // explicit load beats any flip; ack+force flip once
      if (tog_ld_stb_i)  tog_q <= tog_val_i;
      else if (clr)      tog_q <= ~tog_q;

      if (clr)           cnt_q <= '0;
      else if (can_load) cnt_q <= cnt_q + 1'b1;

      if (clr)                                    pkt_rdy_q <= 1'b0;
      else if (rdy_set_stb_i || (auto_rdy_i && hit_mps)) pkt_rdy_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign pkt_rdy_o = pkt_rdy_q;
  assign tog_o     = tog_q;
  assign flush_o   = flush_q;
endmodule

// File: rtl/tx_ep_dma.sv
module tx_ep_dma
  import tx_ep_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              dma_en_i,
  input  logic              dma_mode_i,
  input  logic              pkt_rdy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] mps_i,
  output logic              req_o
);
  logic room_ok, short_ok;

  assign room_ok  = (int'(cnt_i) + int'(mps_i)) <= FIFO_DEPTH;
  assign short_ok = int'(cnt_i) < int'(mps_i);

  always_comb begin
    if (!dma_en_i || pkt_rdy_i) req_o = 1'b0;
    else if (dma_mode_i)        req_o = short_ok;
    else                        req_o = room_ok;
  end
endmodule

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl
  import tx_ep_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter bit SHARED_FIFO = 1'b1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       load_i,
  input  logic       done_i,
  input  logic       ack_i,
  output logic       dma_req_o,
  output logic       flush_o,
  output logic       err_o,
  output logic       dir_tx_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mps_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pkt_rdy_q, tog_q;
  logic              force_stb, tog_ld_stb, tog_val, rdy_set_stb;

  tx_ep_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .ctrl_o        (ctrl_q),
    .mps_o         (mps_q),
    .force_stb_o   (force_stb),
    .tog_ld_stb_o  (tog_ld_stb),
    .tog_val_o     (tog_val),
    .rdy_set_stb_o (rdy_set_stb),
    .err_o         (err_o)
  );

  tx_ep_pkt #(.FIFO_DEPTH(FIFO_DEPTH)) u_pkt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load_i),
    .done_i        (done_i),
    .ack_i         (ack_i),
    .force_stb_i   (force_stb),
    .tog_ld_stb_i  (tog_ld_stb),
    .tog_val_i     (tog_val),
    .rdy_set_stb_i (rdy_set_stb),
    .auto_rdy_i    (ctrl_q.auto_rdy),
    .mps_i         (mps_q),
    .cnt_o         (cnt_q),
    .pkt_rdy_o     (pkt_rdy_q),
    .tog_o         (tog_q),
    .flush_o       (flush_o)
  );

  tx_ep_dma #(.FIFO_DEPTH(FIFO_DEPTH)) u_dma (
    .dma_en_i   (ctrl_q.dma_en),
    .dma_mode_i (ctrl_q.dma_mode),
    .pkt_rdy_i  (pkt_rdy_q),
    .cnt_i      (cnt_q),
    .mps_i      (mps_q),
    .req_o      (dma_req_o)
  );

  generate
    if (SHARED_FIFO) begin : g_shared
      assign dir_tx_o = ctrl_q.dir_tx;
    end else begin : g_fixed
      logic unused_dir;
      assign unused_dir = ctrl_q.dir_tx;
      assign dir_tx_o   = 1'b1;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (addr_e'(addr_i))
      A_STAT: rdata_o[0] = pkt_rdy_q;
      A_CTRL: begin
        rdata_o[CB_EN]   = ctrl_q.dma_en;
        rdata_o[CB_MODE] = ctrl_q.dma_mode;
        rdata_o[CB_AUTO] = ctrl_q.auto_rdy;
        rdata_o[CB_DIR]  = ctrl_q.dir_tx;
        rdata_o[CB_TVAL] = tog_q;
      end
      A_MPS:  rdata_o = mps_q;
      A_CNT:  rdata_o = 8'(cnt_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tx_ep_ctrl_chk.sv
module tx_ep_ctrl_chk
  import tx_ep_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [7:0]        wdata_i,
  input logic              load_i,
  input logic              done_i,
  input logic              ack_i,
  input logic              force_stb,
  input logic              tog_ld_stb,
  input logic              tog_val,
  input ctrl_t             ctrl_q,
  input logic [DATA_W-1:0] mps_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pkt_rdy_q,
  input logic              tog_q,
  input logic              dma_req_o,
  input logic              flush_o,
  input logic              err_o
);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= FIFO_DEPTH);

  // R3
  auto_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ctrl_q.auto_rdy && !force_stb && !(done_i && ack_i) &&
    (int'(cnt_q) < FIFO_DEPTH) && (int'(cnt_q) + 1 == int'(mps_q)) |=> pkt_rdy_q);

  // R4
  ack_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ack_i && !tog_ld_stb |=> tog_q != $past(tog_q));

  // R4
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ack_i |=> (cnt_q == '0) && !pkt_rdy_q);

  // R5
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_stb |=> flush_o && (cnt_q == '0));

  // R6
  tog_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_ld_stb |=> tog_q == $past(tog_val));

  // R7
  dma_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.dma_en |-> !dma_req_o);

  // R7
  dma_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.dma_mode && int'(cnt_q) >= int'(mps_q) |-> !dma_req_o);

  // R8
  order_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 2'd1 && ctrl_q.dma_en && ctrl_q.dma_mode &&
    !wdata_i[CB_MODE] |=> err_o);
endmodule

bind tx_ep_ctrl tx_ep_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .load_i     (load_i),
  .done_i     (done_i),
  .ack_i      (ack_i),
  .force_stb  (force_stb),
  .tog_ld_stb (tog_ld_stb),
  .tog_val    (tog_val),
  .ctrl_q     (ctrl_q),
  .mps_q      (mps_q),
  .cnt_q      (cnt_q),
  .pkt_rdy_q  (pkt_rdy_q),
  .tog_q      (tog_q),
  .dma_req_o  (dma_req_o),
  .flush_o    (flush_o),
  .err_o      (err_o)
);

// File: tb/tx_ep_ctrl_test.sv
`timescale 1ns/1ps
module tx_ep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       load = 1'b0, done = 1'b0, ack = 1'b0;
  logic       dma_req, flush, err, dir_tx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tx_ep_ctrl #(.FIFO_DEPTH(64), .SHARED_FIFO(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .load_i(load), .done_i(done),
    .ack_i(ack), .dma_req_o(dma_req), .flush_o(flush), .err_o(err),
    .dir_tx_o(dir_tx)
  );

  // {wr_addr, wr_data, loads, rd_addr, rd_expect, req_expect}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {2'd2, 8'h04, 6'd0, 2'd2, 8'h04, 1'b0},  // R10 mps readback
    {2'd1, 8'h04, 6'd3, 2'd3, 8'h03, 1'b0},  // R2 count
    {2'd1, 8'h04, 6'd1, 2'd0, 8'h01, 1'b0},  // R3 auto ready at mps
    {2'd1, 8'h14, 6'd0, 2'd3, 8'h00, 1'b0},  // R5 force clears count
    {2'd1, 8'h04, 6'd0, 2'd1, 8'h44, 1'b0},  // R5 toggle flipped
    {2'd1, 8'h25, 6'd0, 2'd1, 8'h05, 1'b1},  // R6 load 0, R7 mode0 req
    {2'd1, 8'h07, 6'd2, 2'd3, 8'h02, 1'b1},  // R7 mode1 below mps
    {2'd1, 8'h03, 6'd2, 2'd3, 8'h04, 1'b0},  // R7 mode1 full, R3 no auto
    {2'd1, 8'h01, 6'd0, 2'd0, 8'h00, 1'b1},  // R3 stays clear, R7 mode0
    {2'd0, 8'h01, 6'd0, 2'd0, 8'h01, 1'b0},  // R3 software set
    {2'd3, 8'hff, 6'd0, 2'd3, 8'h04, 1'b0},  // R10 count not writable
    {2'd1, 8'h89, 6'd0, 2'd1, 8'h09, 1'b0}   // R10 bit7 reserved, R9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic dn, input logic ak);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; done = dn; ack = ak;
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0; ack = 1'b0;
  endtask

  task automatic pulse_done(input logic ak);
    @(negedge clk);
    done = 1'b1; ack = ak;
    @(negedge clk);
    done = 1'b0; ack = 1'b0;
  endtask

  task automatic loads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); load = 1'b1;
    end
    @(negedge clk); load = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reg", r, 8'h00);
    end
    chk("R1 outs", {4'h0, dma_req, flush, err, dir_tx}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][26:25], VEC[v][24:17], 1'b0, 1'b0);
      if (VEC[v][16:11] != 0) loads(int'(VEC[v][16:11]));
      rd(VEC[v][10:9], r);
      chk($sformatf("vec%0d R2 R3 R5 R6 R7 R10", v), r, VEC[v][8:1]);
      chk($sformatf("vec%0d R7 req", v), {7'h0, dma_req}, {7'h0, VEC[v][0]});
    end

    // R4 ack completion: toggle 0->1, count and ready cleared
    pulse_done(1'b1);
    rd(2'd1, r); chk("R4 toggle", r, 8'h49);
    rd(2'd3, r); chk("R4 count", r, 8'h00);
    rd(2'd0, r); chk("R4 ready", r, 8'h00);
    // R4 no ack: nothing changes
    loads(2);
    pulse_done(1'b0);
    rd(2'd1, r); chk("R4 noack toggle", r, 8'h49);
    rd(2'd3, r); chk("R4 noack count", r, 8'h02);

    // R5 force + ack same cycle: flip once (1->0)
    wr(2'd1, 8'h19, 1'b1, 1'b1);
    chk("R5 flush high", {7'h0, flush}, 8'h01);
    rd(2'd1, r); chk("R5 single flip", r, 8'h09);
    @(negedge clk);
    chk("R5 flush one cycle", {7'h0, flush}, 8'h00);

    // R6 load beats ack flip
    wr(2'd1, 8'h69, 1'b1, 1'b1);
    rd(2'd1, r); chk("R6 load priority", r, 8'h49);

    // R8 ordering error
    wr(2'd1, 8'h0b, 1'b0, 1'b0);
    chk("R8 no err on set", {7'h0, err}, 8'h00);
    wr(2'd1, 8'h08, 1'b0, 1'b0);
    chk("R8 err pulse", {7'h0, err}, 8'h01);
    @(negedge clk);
    chk("R8 err one cycle", {7'h0, err}, 8'h00);
    wr(2'd1, 8'h0a, 1'b0, 1'b0);
    wr(2'd1, 8'h08, 1'b0, 1'b0);
    chk("R8 no err with enable off", {7'h0, err}, 8'h00);

    // R9 direction
    chk("R9 dir tx", {7'h0, dir_tx}, 8'h01);
    wr(2'd1, 8'h00, 1'b0, 1'b0);
    chk("R9 dir rx", {7'h0, dir_tx}, 8'h00);

    // R2 saturation, R10 status reserved bits
    loads(70);
    rd(2'd3, r); chk("R2 saturate", r, 8'h40);
    wr(2'd0, 8'hfe, 1'b0, 1'b0);
    rd(2'd0, r); chk("R10 status reserved", r, 8'h00);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    rd(2'd2, r); chk("R1 mps after reset", r, 8'h00);
    rd(2'd3, r); chk("R1 count after reset", r, 8'h00);
    summary();
  end
endmodule